// File: doc/BRIEF.md
# Banked Integer Register File with Poison Tags

This block is the integer register storage of a wide datapath: 128 architectural registers of 64 bits each, served by two combinational read ports and one synchronous write port. Every register carries one extra poison bit beside its data. A set poison bit says the value cannot be trusted, for example because it came from a speculative load that did not complete. Each read returns the data with its poison bit, and each write stores a poison bit built as the OR of the poison bits of the operands that produced the result. An invalid value therefore keeps its mark through any chain of copies and arithmetic until software deals with it.

Index 0 is a fixed zero with a clear poison bit. A write aimed at it is discarded and reported on a one-cycle error output. Indices 16 through 31 exist in two physical copies. A bank-select input picks the copy that both reads and writes of those indices reach: 0 selects the application copy, 1 the interrupt-handler copy. A handler can get a private set of working registers by flipping one input, with nothing saved to memory. The copy that is not selected keeps its contents.

Top module: `rf_poison_banked`

## Requirements
- R1: A synchronous active-high reset clears the data and the poison bit of every register in both copies, and clears the error output. After reset every read returns zero data with poison 0.
- R2: A write with wr_en high stores wr_data at wr_idx on the rising edge. From the next cycle on, both read ports return that data and its poison bit for that index.
- R3: Index 0 always reads zero data with poison 0 on both ports. A write to index 0 changes no stored state.
- R4: When wr_en is high and wr_idx is 0 at a rising edge, wr_illegal is 1 for exactly the following cycle. A write to any other index, or no write, leaves wr_illegal at 0 in the following cycle.
- R5: The stored poison bit equals the OR of all wr_poison_src bits. If any source bit is 1 the stored poison is 1, and if all are 0 it is 0.
- R6: For indices 16 to 31, bank_sel 0 selects the application copy and bank_sel 1 selects the interrupt copy, for reads and writes alike. A write to one copy leaves the same index in the other copy unchanged.
- R7: Indices 1 to 15 and 32 to 127 hold a single copy. bank_sel has no effect on what they read or where they are written.
- R8: If a read port's index equals a nonzero wr_idx while wr_en is high, that port returns the incoming wr_data and OR-ed poison in the same cycle.
- R9: A change of bank_sel takes effect on the read outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | 1 | 0 = application copy, 1 = interrupt copy of indices 16..31 |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 7 | Write register index |
| wr_data | input | 64 | Write data |
| wr_poison_src | input | 2 | Poison bits of the result's source operands |
| rd_idx_a | input | 7 | Read port A index |
| rd_data_a | output | 64 | Read port A data |
| rd_poison_a | output | 1 | Read port A poison bit |
| rd_idx_b | input | 7 | Read port B index |
| rd_data_b | output | 64 | Read port B data |
| rd_poison_b | output | 1 | Read port B poison bit |
| wr_illegal | output | 1 | One-cycle pulse after a write attempt to index 0 |

## Verification
The bench targets the edges of the duplicated range, indices 15, 16, 31 and 32, under both bank settings. A design that decodes the range off by one would leak a write into the wrong copy, or let bank_sel disturb a single-copy register. It carries a poisoned value through a copy taken from the read port and checks that the mark survives. A design that dropped the OR would let a clean-looking poisoned result escape. Writes to index 0 are issued repeatedly, including back to back, and two faults would show there: a design that stored them would return nonzero data, and a design with a stuck or stretched error pulse would show wr_illegal on the wrong cycles. Same-cycle read-after-write and a bank flip with no clock edge expose a registered read path, which would return stale values.

// File: rtl/rf_poison_pkg.sv
package rf_poison_pkg;

    parameter int unsigned XLEN     = 64;
    parameter int unsigned NREGS    = 128;
    parameter int unsigned BANK_LO  = 16;
    parameter int unsigned BANK_HI  = 31;
    parameter int unsigned NSRC     = 2;

    localparam int unsigned IDXW     = $clog2(NREGS);
    localparam int unsigned BANK_CNT = BANK_HI - BANK_LO + 1;
    localparam int unsigned PHYS     = NREGS + BANK_CNT;
    localparam int unsigned PIDXW    = $clog2(PHYS);

    typedef logic [IDXW-1:0]  idx_t;
    typedef logic [PIDXW-1:0] pidx_t;

    typedef struct packed {
        logic            poison;
        logic [XLEN-1:0] data;
    } rf_word_t;

    typedef struct packed {
        logic     en;
        idx_t     idx;
        rf_word_t word;
    } rf_wreq_t;

    localparam rf_word_t RF_ZERO = '{poison: 1'b0, data: '0};

    function automatic logic in_banked(idx_t idx);
        return (idx >= idx_t'(BANK_LO)) && (idx <= idx_t'(BANK_HI));
    endfunction

    // Logical index plus bank select to a slot in the flat storage array.
    // The interrupt copy of the banked range sits above the shared slots.
    function automatic pidx_t to_phys(idx_t idx, logic bank);
        if (bank && in_banked(idx))
            return pidx_t'(NREGS) + pidx_t'(idx - idx_t'(BANK_LO));
        return pidx_t'(idx);
    endfunction

endpackage

// File: rtl/rf_write_ctrl.sv
module rf_write_ctrl
    import rf_poison_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  idx_t                 wr_idx,
    input  logic [XLEN-1:0]      wr_data,
    input  logic [NSRC-1:0]      wr_poison_src,
    output rf_wreq_t             wreq,
    output logic                 illegal_q
);

    logic hits_zero;

    always_comb begin
        hits_zero        = wr_en && (wr_idx == '0);
        wreq.en          = wr_en && !hits_zero;
        wreq.idx         = wr_idx;
        wreq.word.data   = wr_data;
        wreq.word.poison = |wr_poison_src;
    end

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= hits_zero;
    end

endmodule

// File: rtl/rf_store.sv
module rf_store
    import rf_poison_pkg::*;
#(
    parameter int unsigned NRD = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  pidx_t    waddr,
    input  rf_word_t wword,
    input  pidx_t    raddr [NRD],
    output rf_word_t rword [NRD]
);

    rf_word_t mem [PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(PHYS); i++) mem[i] <= RF_ZERO;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wword;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        always_comb rword[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_poison_pkg::*;
(
    input  idx_t     rd_idx,
    input  logic     bank,
    input  rf_wreq_t wreq,
    output pidx_t    raddr,
    input  rf_word_t stored,
    output rf_word_t rd_word
);

    logic bypass;

    always_comb begin
        raddr  = to_phys(rd_idx, bank);
        bypass = wreq.en && (wreq.idx == rd_idx);
        if (rd_idx == '0)
            rd_word = RF_ZERO;
        else if (bypass)
            rd_word = wreq.word;
        else
            rd_word = stored;
    end

endmodule

// File: rtl/rf_poison_banked.sv
module rf_poison_banked
    import rf_poison_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bank_sel,
    input  logic             wr_en,
    input  logic [6:0]       wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [1:0]       wr_poison_src,
    input  logic [6:0]       rd_idx_a,
    output logic [63:0]      rd_data_a,
    output logic             rd_poison_a,
    input  logic [6:0]       rd_idx_b,
    output logic [63:0]      rd_data_b,
    output logic             rd_poison_b,
    output logic             wr_illegal
);

    localparam int unsigned NRD = 2;

    rf_wreq_t wreq;
    pidx_t    raddr   [NRD];
    rf_word_t stored  [NRD];
    rf_word_t rd_word [NRD];
    idx_t     rd_idx  [NRD];

    assign rd_idx[0] = rd_idx_a;
    assign rd_idx[1] = rd_idx_b;

    rf_write_ctrl u_wctl (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .wr_poison_src (wr_poison_src),
        .wreq          (wreq),
        .illegal_q     (wr_illegal)
    );

    rf_store #(.NRD(NRD)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wreq.en),
        .waddr (to_phys(wreq.idx, bank_sel)),
        .wword (wreq.word),
        .raddr (raddr),
        .rword (stored)
    );

    for (genvar p = 0; p < int'(NRD); p++) begin : g_port
        rf_read_port u_rp (
            .rd_idx  (rd_idx[p]),
            .bank    (bank_sel),
            .wreq    (wreq),
            .raddr   (raddr[p]),
            .stored  (stored[p]),
            .rd_word (rd_word[p])
        );
    end

    assign rd_data_a   = rd_word[0].data;
    assign rd_poison_a = rd_word[0].poison;
    assign rd_data_b   = rd_word[1].data;
    assign rd_poison_b = rd_word[1].poison;

endmodule

// File: rtl/rf_poison_banked_chk.sv
module rf_poison_banked_chk (
    input logic        clk,
    input logic        rst,
    input logic        bank_sel,
    input logic        wr_en,
    input logic [6:0]  wr_idx,
    input logic [63:0] wr_data,
    input logic [1:0]  wr_poison_src,
    input logic [6:0]  rd_idx_a,
    input logic [63:0] rd_data_a,
    input logic        rd_poison_a,
    input logic [6:0]  rd_idx_b,
    input logic [63:0] rd_data_b,
    input logic        rd_poison_b,
    input logic        wr_illegal
);

    assert_zero_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == 7'd0) |-> (rd_data_a == 64'd0 && !rd_poison_a));

    assert_zero_read_b_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_b == 7'd0) |-> (rd_data_b == 64'd0 && !rd_poison_b));

    assert_illegal_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 7'd0) |=> wr_illegal);

    assert_no_spurious_illegal_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == 7'd0) |=> !wr_illegal);

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 7'd0 && wr_idx == rd_idx_a)
        |-> (rd_data_a == wr_data && rd_poison_a == |wr_poison_src));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != 7'd0)
        |=> ((rd_idx_b != $past(wr_idx)) || (bank_sel != $past(bank_sel))
             || (wr_en && wr_idx == rd_idx_b)
             || (rd_data_b == $past(wr_data) && rd_poison_b == |$past(wr_poison_src))));

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((wr_en && wr_idx == rd_idx_a)
                        || (rd_data_a == 64'd0 && !rd_poison_a)));

endmodule

bind rf_poison_banked rf_poison_banked_chk u_chk (.*);

// File: tb/tb_rf_poison_banked.sv
`timescale 1ns/1ps
module tb_rf_poison_banked;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_poison_src = '0;
    logic [6:0]  rd_idx_a = '0;
    logic [63:0] rd_data_a;
    logic        rd_poison_a;
    logic [6:0]  rd_idx_b = '0;
    logic [63:0] rd_data_b;
    logic        rd_poison_b;
    logic        wr_illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [64:0] m_app [128];
    logic [15:0][64:0] m_int;
    logic exp_ill = 1'b0;

    rf_poison_banked dut (.*);

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic banked(logic [6:0] i);
        return i >= 7'd16 && i <= 7'd31;
    endfunction

    function automatic logic [64:0] mread(logic [6:0] i, logic b);
        if (i == 7'd0) return '0;
        if (b && banked(i)) return m_int[i - 7'd16];
        return m_app[i];
    endfunction

    function automatic logic [64:0] exp_rd(logic [6:0] i);
        if (i != 7'd0 && wr_en && wr_idx == i) return {|wr_poison_src, wr_data};
        return mread(i, bank_sel);
    endfunction

    task automatic chk(string req, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_ports(string req);
        #1;
        chk(req, {rd_poison_a, rd_data_a}, exp_rd(rd_idx_a));
        chk(req, {rd_poison_b, rd_data_b}, exp_rd(rd_idx_b));
        chk({req, "/R4"}, {64'd0, wr_illegal}, {64'd0, exp_ill});
    endtask

    // one clock: check combinational outputs, then update the model at the edge
    task automatic cyc(string req);
        check_ports(req);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 128; i++) m_app[i] = '0;
            for (int i = 0; i < 16; i++) m_int[i] = '0;
            exp_ill = 1'b0;
        end else begin
            exp_ill = wr_en && wr_idx == 7'd0;
            if (wr_en && wr_idx != 7'd0) begin
                if (bank_sel && banked(wr_idx)) m_int[wr_idx - 7'd16] = {|wr_poison_src, wr_data};
                else m_app[wr_idx] = {|wr_poison_src, wr_data};
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [6:0] i, logic [63:0] d, logic [1:0] p, string req);
        wr_en = 1'b1; wr_idx = i; wr_data = d; wr_poison_src = p;
        cyc(req);
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 128; i++) m_app[i] = 'x;
        for (int i = 0; i < 16; i++) m_int[i] = 'x;
        @(negedge clk);
        cyc("R1 reset");
        cyc("R1 reset");
        rst = 1'b0;
        // R1: every index in both banks reads zero after reset
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 128; i++) begin
                bank_sel = b[0]; rd_idx_a = 7'(i); rd_idx_b = 7'(127 - i);
                #1;
                chk("R1 reset state", {rd_poison_a, rd_data_a}, 65'd0);
            end
        bank_sel = 1'b0;
        @(negedge clk);

        // R2 and R8: write then read, same-cycle bypass
        rd_idx_a = 7'd9; rd_idx_b = 7'd9;
        wr(7'd9, 64'hDEAD_BEEF_0123_4567, 2'b00, "R8 bypass");
        cyc("R2 write lands");

        // R3 and R4: writes to index 0, back to back
        rd_idx_a = 7'd0; rd_idx_b = 7'd0;
        wr(7'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, "R3 zero write");
        wr(7'd0, 64'h1234, 2'b01, "R3 zero write b2b");
        cyc("R4 pulse after b2b");
        cyc("R4 pulse ends");
        chk("R3 zero read", {rd_poison_a, rd_data_a}, 65'd0);

        // R5: poison travels through a copy taken from the read port
        wr(7'd5, 64'hA5A5_0000_1111_2222, 2'b10, "R5 seed");
        rd_idx_a = 7'd5; rd_idx_b = 7'd7; #1;
        wr_en = 1'b1; wr_idx = 7'd6; wr_data = rd_data_a;
        wr_poison_src = {rd_poison_a, rd_poison_b};
        cyc("R5 copy");
        wr_en = 1'b0;
        rd_idx_a = 7'd6; #1;
        chk("R5 copy poisoned", {rd_poison_a, rd_data_a}, {1'b1, 64'hA5A5_0000_1111_2222});
        wr(7'd7, 64'h77, 2'b00, "R5 clean");
        rd_idx_a = 7'd7; #1;
        chk("R5 clean sources", {rd_poison_a, rd_data_a}, {1'b0, 64'h77});

        // R6, R7, R9: range edges under both banks
        for (int b = 0; b < 2; b++) begin
            bank_sel = b[0];
            wr(7'd15, 64'h1500 + 64'(b), 2'(b), "R7 edge 15");
            wr(7'd16, 64'h1600 + 64'(b), 2'(b), "R6 edge 16");
            wr(7'd31, 64'h3100 + 64'(b), 2'(b), "R6 edge 31");
            wr(7'd32, 64'h3200 + 64'(b), 2'(b), "R7 edge 32");
        end
        rd_idx_a = 7'd16; rd_idx_b = 7'd31;
        bank_sel = 1'b0; #1;
        chk("R9 app copy 16", {rd_poison_a, rd_data_a}, {1'b0, 64'h1600});
        chk("R6 app copy 31", {rd_poison_b, rd_data_b}, {1'b0, 64'h3100});
        bank_sel = 1'b1; #1;
        chk("R9 int copy 16", {rd_poison_a, rd_data_a}, {1'b1, 64'h1601});
        chk("R6 int copy 31", {rd_poison_b, rd_data_b}, {1'b1, 64'h3101});
        rd_idx_a = 7'd15; rd_idx_b = 7'd32;
        bank_sel = 1'b0; #1;
        chk("R7 single 15", {rd_poison_a, rd_data_a}, {1'b1, 64'h1501});
        chk("R7 single 32", {rd_poison_b, rd_data_b}, {1'b1, 64'h3201});
        @(negedge clk);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r < 5) bank_sel = ~bank_sel;
            wr_en = $urandom_range(0, 3) != 0;
            r = $urandom_range(0, 15);
            wr_idx = (r == 0) ? 7'd0 : (r < 8) ? 7'(16 + $urandom_range(0, 15))
                                               : 7'($urandom_range(1, 127));
            wr_data = {$urandom, $urandom};
            wr_poison_src = 2'($urandom_range(0, 3));
            r = $urandom_range(0, 3);
            rd_idx_a = (r == 0) ? wr_idx : (r == 1) ? 7'(16 + $urandom_range(0, 15))
                                                    : 7'($urandom_range(0, 127));
            rd_idx_b = 7'($urandom_range(0, 127));
            cyc("R2/R6/R8 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule